// File: doc/BRIEF.md
# UART DMA Channel Controller

This block is a single channel of a peripheral DMA engine that moves bytes between system memory and a UART. In transmit mode it reads bytes from memory and hands them to the UART transmit FIFO. In receive mode it takes bytes from the UART receive FIFO and writes them to memory. Software programs the channel through a small word-addressed register window. The window holds a bank of descriptor slots, each with a start address and a byte count. A descriptor control word marks which slots are live, which one ends the chain, and which events may interrupt.

The channel works through the live slots from the lowest index upward. Each transfer advances the slot's address and reduces its count, so the remaining byte count can be read back at any time to compute a residue. Completion, receive idle timeout and bus error each set a flag in a status register. Reading that register clears it. An interrupt line is high while any enabled flag is pending. In a larger engine, instances with even index are wired for transmit and instances with odd index for receive, and each pair serves one UART port. The register windows of the instances repeat at a fixed stride.

Top module: `uart_dma_chan`

## Requirements
- R1: After reset, the control word (index 0), the descriptor control word (index 1) and the status word (index 5) read 0, `irq` is low, and no memory, transmit or receive handshake is driven.
- R2: The burst word (index 2), the width word (index 3) and the idle timeout word (index 4) read back the values written to them. The burst and width values also appear on `dev_burst` and `dev_width`.
- R3: With control bit 1 (direction) = 0 and bit 0 (run) = 1, each byte is read from memory at the slot address and offered on `tx_data` until it is accepted. After acceptance the slot address (index 8+2i) goes up by one and its count (index 9+2i) goes down by one. The count reads back the bytes still to move.
- R4: With direction = 1 and run = 1, each byte popped from the receive FIFO is written to memory at the slot address, with the same address and count updates as in R3.
- R5: The live slots, marked by descriptor control bits [3:0], are served in ascending index order and non-live slots are skipped. A finished slot loses its live bit. After finishing a slot whose stop bit (bits [11:8]) is set, the channel clears the run bit and goes idle.
- R6: A live slot whose count is 0 finishes without any transfer and still raises its done flag.
- R7: Status bits [3:0] are per-slot done flags, bits [7:4] are per-slot timeout flags and bit 8 is the error flag. A read of index 5 returns the pending flags and clears them.
- R8: `irq` is high exactly while some pending flag is enabled. Done flags are enabled by descriptor control bits [15:12], timeout flags by bits [7:4] and the error flag by bit 17. A pending flag that is not enabled leaves `irq` low.
- R9: Writing 0 to the control word withdraws every request in the same cycle and keeps all slot contents. Setting run again resumes the interrupted transfer.
- R10: In receive mode, once a slot has taken at least one byte, the slot's timeout flag is raised after the receive FIFO has stayed empty for the number of cycles in the idle timeout word. The partial count stays readable, and the slot goes on when data returns.
- R11: A memory access that ends with `mem_err` raises the error flag and uses up that byte. If descriptor control bit 16 (stop on error) is set, the channel clears its run bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | RAW | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory access complete |
| mem_err | input | 1 | Memory access failed, valid with `mem_ack` |
| tx_valid | output | 1 | Byte offered to the transmit FIFO |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmit FIFO accepts the byte |
| rx_valid | input | 1 | Receive FIFO not empty |
| rx_data | input | 8 | Receive FIFO head byte |
| rx_pop | output | 1 | Take the head byte from the receive FIFO |
| dev_burst | output | BURST_W | Burst length for the device side |
| dev_width | output | WIDTH_W | Access width code for the device side |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is the receive idle timeout. The slot must have taken some bytes and must still be unfinished, and then the FIFO must dry up for longer than the threshold. The stimulus builds this with a receive source that releases only part of a slot's bytes and then holds `rx_valid` low. The bench reads back the flag and the partial count, and only then releases the rest of the bytes. A paused transfer is also hard to reach: the bench holds `tx_ready` low so the channel sits on an offered byte, and it clears the run bit at that point.

// File: rtl/uart_dma_pkg.sv
package uart_dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_MRD  = 3'd1,
    ST_TXP  = 3'd2,
    ST_RXW  = 3'd3,
    ST_MWR  = 3'd4
  } eng_st_t;

  localparam int unsigned IX_CTRL  = 0;
  localparam int unsigned IX_DCTRL = 1;
  localparam int unsigned IX_BURST = 2;
  localparam int unsigned IX_WIDTH = 3;
  localparam int unsigned IX_TMO   = 4;
  localparam int unsigned IX_STAT  = 5;
  localparam int unsigned IX_SLOT0 = 8;
endpackage

// File: rtl/uart_dma_regs.sv
module uart_dma_regs
  import uart_dma_pkg::*;
#(
  parameter int NSLOT   = 4,
  parameter int RAW     = 6,
  parameter int AW      = 32,
  parameter int SW      = 16,
  parameter int TW      = 16,
  parameter int BURST_W = 8,
  parameter int WIDTH_W = 3,
  parameter int IDX_W   = 2,
  parameter int FLAG_W  = 9
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr,
  input  logic                         rd,
  input  logic [RAW-1:0]               addr,
  input  logic [31:0]                  wdata,
  output logic [31:0]                  rdata,
  input  logic                         upd_en,
  input  logic [IDX_W-1:0]             upd_idx,
  input  logic                         done_en,
  input  logic [IDX_W-1:0]             done_idx,
  input  logic                         halt,
  input  logic [FLAG_W-1:0]            flags,
  output logic                         stat_clr,
  output logic                         ctrl_act,
  output logic                         ctrl_dir,
  output logic [NSLOT-1:0]             slot_act,
  output logic [NSLOT-1:0]             to_ie,
  output logic [NSLOT-1:0]             stop_vec,
  output logic [NSLOT-1:0]             done_ie,
  output logic                         soe,
  output logic                         eie,
  output logic [BURST_W-1:0]           burst,
  output logic [WIDTH_W-1:0]           width,
  output logic [TW-1:0]                tmo,
  output logic [NSLOT-1:0][AW-1:0]     slot_addr,
  output logic [NSLOT-1:0][SW-1:0]     slot_size
);
  logic                     act_n, dir_n;
  logic [NSLOT-1:0]         sact_n, toie_n, stop_n, dnie_n;
  logic                     soe_n, eie_n;
  logic [BURST_W-1:0]       burst_n;
  logic [WIDTH_W-1:0]       width_n;
  logic [TW-1:0]            tmo_n;
  logic [NSLOT-1:0][AW-1:0] addr_n;
  logic [NSLOT-1:0][SW-1:0] size_n;
  logic [31:0]              rmux;

  assign stat_clr = rd && (addr == RAW'(IX_STAT));

  always_comb begin
    act_n   = ctrl_act;
    dir_n   = ctrl_dir;
    sact_n  = slot_act;
    toie_n  = to_ie;
    stop_n  = stop_vec;
    dnie_n  = done_ie;
    soe_n   = soe;
    eie_n   = eie;
    burst_n = burst;
    width_n = width;
    tmo_n   = tmo;
    addr_n  = slot_addr;
    size_n  = slot_size;
    if (halt) act_n = 1'b0;
    if (done_en) sact_n[done_idx] = 1'b0;
    if (upd_en) begin
      addr_n[upd_idx] = slot_addr[upd_idx] + AW'(1);
      size_n[upd_idx] = slot_size[upd_idx] - SW'(1);
    end
    if (wr) begin
      if (addr == RAW'(IX_CTRL)) begin
        act_n = wdata[0];
        dir_n = wdata[1];
      end
      if (addr == RAW'(IX_DCTRL)) begin
        sact_n = wdata[0 +: NSLOT];
        toie_n = wdata[NSLOT +: NSLOT];
        stop_n = wdata[2*NSLOT +: NSLOT];
        dnie_n = wdata[3*NSLOT +: NSLOT];
        soe_n  = wdata[4*NSLOT];
        eie_n  = wdata[4*NSLOT+1];
      end
      if (addr == RAW'(IX_BURST)) burst_n = wdata[BURST_W-1:0];
      if (addr == RAW'(IX_WIDTH)) width_n = wdata[WIDTH_W-1:0];
      if (addr == RAW'(IX_TMO))   tmo_n   = wdata[TW-1:0];
      for (int i = 0; i < NSLOT; i++) begin
        if (addr == RAW'(IX_SLOT0 + 2*i))     addr_n[i] = wdata[AW-1:0];
        if (addr == RAW'(IX_SLOT0 + 2*i + 1)) size_n[i] = wdata[SW-1:0];
      end
    end
  end

  always_comb begin
    rmux = '0;
    if (addr == RAW'(IX_CTRL)) rmux[1:0] = {ctrl_dir, ctrl_act};
    if (addr == RAW'(IX_DCTRL)) begin
      rmux[0 +: NSLOT]       = slot_act;
      rmux[NSLOT +: NSLOT]   = to_ie;
      rmux[2*NSLOT +: NSLOT] = stop_vec;
      rmux[3*NSLOT +: NSLOT] = done_ie;
      rmux[4*NSLOT]          = soe;
      rmux[4*NSLOT+1]        = eie;
    end
    if (addr == RAW'(IX_BURST)) rmux[BURST_W-1:0] = burst;
    if (addr == RAW'(IX_WIDTH)) rmux[WIDTH_W-1:0] = width;
    if (addr == RAW'(IX_TMO))   rmux[TW-1:0]      = tmo;
    if (addr == RAW'(IX_STAT))  rmux[FLAG_W-1:0]  = flags;
    for (int i = 0; i < NSLOT; i++) begin
      if (addr == RAW'(IX_SLOT0 + 2*i))     rmux[AW-1:0] = slot_addr[i];
      if (addr == RAW'(IX_SLOT0 + 2*i + 1)) rmux[SW-1:0] = slot_size[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_act  <= 1'b0;
      ctrl_dir  <= 1'b0;
      slot_act  <= '0;
      to_ie     <= '0;
      stop_vec  <= '0;
      done_ie   <= '0;
      soe       <= 1'b0;
      eie       <= 1'b0;
      burst     <= '0;
      width     <= '0;
      tmo       <= '0;
      slot_addr <= '0;
      slot_size <= '0;
      rdata     <= '0;
    end else begin
      ctrl_act  <= act_n;
      ctrl_dir  <= dir_n;
      slot_act  <= sact_n;
      to_ie     <= toie_n;
      stop_vec  <= stop_n;
      done_ie   <= dnie_n;
      soe       <= soe_n;
      eie       <= eie_n;
      burst     <= burst_n;
      width     <= width_n;
      tmo       <= tmo_n;
      slot_addr <= addr_n;
      slot_size <= size_n;
      if (rd) rdata <= rmux;
    end
  end
endmodule

// File: rtl/uart_dma_status.sv
module uart_dma_status #(
  parameter int NSLOT  = 4,
  parameter int IDX_W  = 2,
  parameter int FLAG_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_en,
  input  logic [IDX_W-1:0]  done_idx,
  input  logic              to_en,
  input  logic [IDX_W-1:0]  to_idx,
  input  logic              err_en,
  input  logic              clr,
  input  logic [NSLOT-1:0]  done_ie,
  input  logic [NSLOT-1:0]  to_ie,
  input  logic              eie,
  output logic [FLAG_W-1:0] flags,
  output logic              irq
);
  logic [FLAG_W-1:0] set_v, flags_n;

  always_comb begin
    set_v = '0;
    if (done_en) set_v[done_idx] = 1'b1;
    if (to_en)   set_v[NSLOT + int'(to_idx)] = 1'b1;
    set_v[2*NSLOT] = err_en;
    flags_n = (clr ? '0 : flags) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_n;
  end

  assign irq = (|(flags[NSLOT-1:0] & done_ie)) |
               (|(flags[2*NSLOT-1:NSLOT] & to_ie)) |
               (flags[2*NSLOT] & eie);
endmodule

// File: rtl/uart_dma_engine.sv
module uart_dma_engine
  import uart_dma_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int AW    = 32,
  parameter int SW    = 16,
  parameter int TW    = 16,
  parameter int IDX_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     act,
  input  logic                     dir,
  input  logic [NSLOT-1:0]         slot_act,
  input  logic [NSLOT-1:0]         stop_vec,
  input  logic                     soe,
  input  logic [TW-1:0]            tmo,
  input  logic [NSLOT-1:0][AW-1:0] slot_addr,
  input  logic [NSLOT-1:0][SW-1:0] slot_size,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [AW-1:0]            mem_addr,
  output logic [7:0]               mem_wdata,
  input  logic [7:0]               mem_rdata,
  input  logic                     mem_ack,
  input  logic                     mem_err,
  output logic                     tx_valid,
  output logic [7:0]               tx_data,
  input  logic                     tx_ready,
  input  logic                     rx_valid,
  input  logic [7:0]               rx_data,
  output logic                     rx_pop,
  output logic                     upd_en,
  output logic [IDX_W-1:0]         beat_idx,
  output logic                     done_en,
  output logic [IDX_W-1:0]         done_idx,
  output logic                     halt,
  output logic                     to_en,
  output logic                     err_en
);
  eng_st_t          st_q, st_n;
  logic [IDX_W-1:0] idx_n;
  logic [7:0]       byte_q, byte_n;
  logic             seen_q, seen_n;
  logic [TW-1:0]    cnt_q, cnt_n;
  logic [IDX_W-1:0] cur;
  logic             any_act;

  always_comb begin
    cur = '0;
    for (int i = NSLOT-1; i >= 0; i--) begin
      if (slot_act[i]) cur = IDX_W'(i);
    end
  end
  assign any_act = |slot_act;

  assign mem_req   = act && ((st_q == ST_MRD) || (st_q == ST_MWR));
  assign mem_we    = (st_q == ST_MWR);
  assign mem_addr  = slot_addr[beat_idx];
  assign mem_wdata = byte_q;
  assign tx_valid  = act && (st_q == ST_TXP);
  assign tx_data   = byte_q;
  assign rx_pop    = act && (st_q == ST_RXW) && rx_valid;
  assign done_idx  = cur;

  always_comb begin
    st_n    = st_q;
    idx_n   = beat_idx;
    byte_n  = byte_q;
    seen_n  = seen_q;
    cnt_n   = cnt_q;
    upd_en  = 1'b0;
    done_en = 1'b0;
    halt    = 1'b0;
    to_en   = 1'b0;
    err_en  = 1'b0;
    if (act) begin
      unique case (st_q)
        ST_IDLE: begin
          if (any_act) begin
            if (slot_size[cur] == '0) begin
              done_en = 1'b1;
              seen_n  = 1'b0;
              cnt_n   = '0;
              halt    = stop_vec[cur];
            end else begin
              idx_n = cur;
              st_n  = dir ? ST_RXW : ST_MRD;
            end
          end
        end
        ST_MRD: begin
          if (mem_ack) begin
            if (mem_err) begin
              err_en = 1'b1;
              upd_en = 1'b1;
              halt   = soe;
              st_n   = ST_IDLE;
            end else begin
              byte_n = mem_rdata;
              st_n   = ST_TXP;
            end
          end
        end
        ST_TXP: begin
          if (tx_ready) begin
            upd_en = 1'b1;
            st_n   = ST_IDLE;
          end
        end
        ST_RXW: begin
          if (rx_valid) begin
            byte_n = rx_data;
            seen_n = 1'b1;
            cnt_n  = '0;
            st_n   = ST_MWR;
          end else if (seen_q && (tmo != '0) && (cnt_q != tmo)) begin
            cnt_n = cnt_q + TW'(1);
            to_en = (cnt_q + TW'(1)) == tmo;
          end
        end
        ST_MWR: begin
          if (mem_ack) begin
            upd_en = 1'b1;
            err_en = mem_err;
            halt   = mem_err && soe;
            st_n   = ST_IDLE;
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      beat_idx <= '0;
      byte_q   <= '0;
      seen_q   <= 1'b0;
      cnt_q    <= '0;
    end else begin
      st_q     <= st_n;
      beat_idx <= idx_n;
      byte_q   <= byte_n;
      seen_q   <= seen_n;
      cnt_q    <= cnt_n;
    end
  end
endmodule

// File: rtl/uart_dma_chan.sv
module uart_dma_chan
  import uart_dma_pkg::*;
#(
  parameter int NSLOT   = 4,
  parameter int RAW     = 6,
  parameter int AW      = 32,
  parameter int SW      = 16,
  parameter int TW      = 16,
  parameter int BURST_W = 8,
  parameter int WIDTH_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [RAW-1:0]     reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               mem_req,
  output logic               mem_we,
  output logic [AW-1:0]      mem_addr,
  output logic [7:0]         mem_wdata,
  input  logic [7:0]         mem_rdata,
  input  logic               mem_ack,
  input  logic               mem_err,
  output logic               tx_valid,
  output logic [7:0]         tx_data,
  input  logic               tx_ready,
  input  logic               rx_valid,
  input  logic [7:0]         rx_data,
  output logic               rx_pop,
  output logic [BURST_W-1:0] dev_burst,
  output logic [WIDTH_W-1:0] dev_width,
  output logic               irq
);
  localparam int IDX_W  = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam int FLAG_W = 2*NSLOT + 1;

  logic [1:0]               rs_q;
  logic                     rst_q_n;
  logic                     ctrl_act, ctrl_dir, soe, eie, stat_clr;
  logic [NSLOT-1:0]         slot_act, to_ie, stop_vec, done_ie;
  logic [TW-1:0]            tmo;
  logic [NSLOT-1:0][AW-1:0] slot_addr;
  logic [NSLOT-1:0][SW-1:0] slot_size;
  logic [FLAG_W-1:0]        flags;
  logic                     upd_en, done_en, halt, to_en, err_en;
  logic [IDX_W-1:0]         beat_idx, done_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q_n = rs_q[1];

  uart_dma_regs #(
    .NSLOT(NSLOT), .RAW(RAW), .AW(AW), .SW(SW), .TW(TW),
    .BURST_W(BURST_W), .WIDTH_W(WIDTH_W), .IDX_W(IDX_W), .FLAG_W(FLAG_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_q_n),
    .wr(reg_wr), .rd(reg_rd), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .upd_en(upd_en), .upd_idx(beat_idx), .done_en(done_en), .done_idx(done_idx),
    .halt(halt), .flags(flags), .stat_clr(stat_clr),
    .ctrl_act(ctrl_act), .ctrl_dir(ctrl_dir), .slot_act(slot_act), .to_ie(to_ie),
    .stop_vec(stop_vec), .done_ie(done_ie), .soe(soe), .eie(eie),
    .burst(dev_burst), .width(dev_width), .tmo(tmo),
    .slot_addr(slot_addr), .slot_size(slot_size)
  );

  uart_dma_engine #(
    .NSLOT(NSLOT), .AW(AW), .SW(SW), .TW(TW), .IDX_W(IDX_W)
  ) u_eng (
    .clk(clk), .rst_n(rst_q_n),
    .act(ctrl_act), .dir(ctrl_dir), .slot_act(slot_act), .stop_vec(stop_vec),
    .soe(soe), .tmo(tmo), .slot_addr(slot_addr), .slot_size(slot_size),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_pop(rx_pop),
    .upd_en(upd_en), .beat_idx(beat_idx), .done_en(done_en), .done_idx(done_idx),
    .halt(halt), .to_en(to_en), .err_en(err_en)
  );

  uart_dma_status #(
    .NSLOT(NSLOT), .IDX_W(IDX_W), .FLAG_W(FLAG_W)
  ) u_stat (
    .clk(clk), .rst_n(rst_q_n),
    .done_en(done_en), .done_idx(done_idx), .to_en(to_en), .to_idx(beat_idx),
    .err_en(err_en), .clr(stat_clr), .done_ie(done_ie), .to_ie(to_ie), .eie(eie),
    .flags(flags), .irq(irq)
  );
endmodule

// File: rtl/uart_dma_chk.sv
module uart_dma_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctrl_act,
  input logic          ctrl_dir,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          rx_pop
);
  // R9: nothing is requested while the run bit is clear
  p_quiet_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_act |-> (!mem_req && !tx_valid && !rx_pop));

  // R3 / R4: at most one handshake is open at a time
  p_one_handshake_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req, tx_valid, rx_pop}));

  // R4: an open memory request holds its address until acknowledged or paused
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && ctrl_act) |=> (!ctrl_act || (mem_req && $stable(mem_addr))));

  // R3: an offered transmit byte stays put until accepted or paused
  p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && ctrl_act) |=> (!ctrl_act || (tx_valid && $stable(tx_data))));

  // R3 / R4: memory writes only in receive mode, transmit only in transmit mode
  p_dir_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_req && mem_we) |-> ctrl_dir) and (tx_valid |-> !ctrl_dir));
endmodule

bind uart_dma_chan uart_dma_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .ctrl_act(ctrl_act), .ctrl_dir(ctrl_dir),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .rx_pop(rx_pop)
);

// File: tb/sim_uart_dma_chan.sv
`timescale 1ns/1ps
module sim_uart_dma_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        mem_ack = 1'b0, mem_err = 1'b0;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b1;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        rx_pop;
  logic [7:0]  dev_burst;
  logic [2:0]  dev_width;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  logic [7:0]  mem [0:255];
  logic [7:0]  rx_buf [0:15];
  int          rx_idx = 0, rx_len = 0;
  logic        err_on = 1'b0;
  logic [7:0]  err_addr = '0;
  logic [7:0]  tx_q [$];
  logic [39:0] wr_q [$];

  always #5 clk = ~clk;

  uart_dma_chan u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .mem_err(mem_err), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_pop(rx_pop), .dev_burst(dev_burst),
    .dev_width(dev_width), .irq(irq)
  );

  // memory model: one-cycle acknowledge pulse
  always @(posedge clk) begin
    mem_ack   <= mem_req && !mem_ack;
    mem_rdata <= mem[mem_addr[7:0]];
    mem_err   <= err_on && (mem_addr[7:0] == err_addr) && mem_req && !mem_ack;
    if (mem_req && mem_we && mem_ack) mem[mem_addr[7:0]] <= mem_wdata;
  end

  // receive FIFO source
  assign rx_valid = rx_idx < rx_len;
  assign rx_data  = rx_buf[rx_idx[3:0]];
  always @(posedge clk) if (rx_pop) rx_idx <= rx_idx + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      n_chk++;
      if (tx_q.size() == 0) begin
        n_fail++;
        $display("FAIL R3 tx byte actual=%h expected=none", tx_data);
      end else begin
        logic [7:0] e;
        e = tx_q.pop_front();
        if (tx_data !== e) begin
          n_fail++;
          $display("FAIL R3 tx byte actual=%h expected=%h", tx_data, e);
        end
      end
    end
    if (rst_n && mem_req && mem_we && mem_ack) begin
      n_chk++;
      if (wr_q.size() == 0) begin
        n_fail++;
        $display("FAIL R4 mem write actual=%h expected=none", {mem_addr, mem_wdata});
      end else begin
        logic [39:0] e;
        e = wr_q.pop_front();
        if ({mem_addr, mem_wdata} !== e) begin
          n_fail++;
          $display("FAIL R4 mem write actual=%h expected=%h", {mem_addr, mem_wdata}, e);
        end
      end
    end
  end

  task automatic wreg(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 6'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 6'(a);
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_irq(input int lim);
    for (int k = 0; k < lim; k++) begin
      @(negedge clk);
      if (irq) break;
    end
  endtask

  task automatic push_tx(input int a, input int n);
    for (int k = 0; k < n; k++) tx_q.push_back(8'(a + k) ^ 8'h5A);
  endtask

  initial begin
    for (int k = 0; k < 100000; k++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic        quiet;
    for (int k = 0; k < 256; k++) mem[k] = 8'(k) ^ 8'h5A;
    for (int k = 0; k < 16; k++) rx_buf[k] = 8'hA0 + 8'(k);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    rreg(0, v); chk("R1 ctrl", v, 0);
    rreg(1, v); chk("R1 dctrl", v, 0);
    rreg(5, v); chk("R1 status", v, 0);
    chk("R1 irq/handshakes", {28'd0, irq, mem_req, tx_valid, rx_pop}, 0);

    // R2 device-side config
    wreg(2, 32'h8); wreg(3, 32'h2); wreg(4, 32'h5);
    rreg(2, v); chk("R2 burst readback", v, 8);
    rreg(3, v); chk("R2 width readback", v, 2);
    rreg(4, v); chk("R2 timeout readback", v, 5);
    chk("R2 dev_burst", 32'(dev_burst), 8);
    chk("R2 dev_width", 32'(dev_width), 2);

    // R3 R5 R6 R7 R8: transmit chain over slots 0,1(empty),2, slot 3 not live
    wreg(8, 32'h10); wreg(9, 2);
    wreg(10, 32'h18); wreg(11, 0);
    wreg(12, 32'h20); wreg(13, 3);
    wreg(14, 32'h30); wreg(15, 2);
    push_tx(32'h10, 2); push_tx(32'h20, 3);
    wreg(1, 32'h4407);
    wreg(0, 32'h1);
    wait_irq(400);
    chk("R8 irq on enabled done", 32'(irq), 1);
    rreg(5, v); chk("R7 R6 done flags", v, 32'h7);
    chk("R8 irq after clear", 32'(irq), 0);
    rreg(5, v); chk("R7 status cleared", v, 0);
    rreg(0, v); chk("R5 halted after stop slot", v, 0);
    rreg(1, v); chk("R5 live bits cleared", v, 32'h4400);
    rreg(12, v); chk("R3 slot2 address advanced", v, 32'h23);
    rreg(13, v); chk("R3 slot2 residue", v, 0);
    rreg(15, v); chk("R5 slot3 untouched", v, 2);
    chk("R3 R5 all tx bytes seen", 32'(tx_q.size()), 0);

    // R9 pause and resume
    tx_ready = 1'b0;
    wreg(8, 32'h70); wreg(9, 2);
    push_tx(32'h70, 2);
    wreg(1, 32'h1101);
    wreg(0, 32'h1);
    repeat (10) @(negedge clk);
    chk("R9 byte offered before pause", 32'(tx_valid), 1);
    wreg(0, 32'h0);
    quiet = 1'b1;
    for (int k = 0; k < 5; k++) begin
      if (tx_valid || mem_req || rx_pop) quiet = 1'b0;
      @(negedge clk);
    end
    chk("R9 quiet while paused", 32'(quiet), 1);
    rreg(9, v); chk("R9 residue kept", v, 2);
    tx_ready = 1'b1;
    wreg(0, 32'h1);
    wait_irq(200);
    rreg(5, v); chk("R9 resumed to completion", v, 32'h1);
    chk("R9 tx bytes after resume", 32'(tx_q.size()), 0);

    // R4 R8 receive into slot 1, done interrupt masked
    wreg(10, 32'h40); wreg(11, 4);
    for (int k = 0; k < 4; k++) wr_q.push_back({32'h40 + 32'(k), rx_buf[k]});
    rx_len = 4;
    wreg(1, 32'h202);
    wreg(0, 32'h3);
    repeat (60) @(negedge clk);
    chk("R8 masked done keeps irq low", 32'(irq), 0);
    rreg(5, v); chk("R4 receive done flag", v, 32'h2);
    rreg(11, v); chk("R4 receive residue", v, 0);
    chk("R4 all writes seen", 32'(wr_q.size()), 0);

    // R10 receive idle timeout, partial slot
    wreg(8, 32'h50); wreg(9, 8);
    for (int k = 0; k < 8; k++) wr_q.push_back({32'h50 + 32'(k), rx_buf[4+k]});
    rx_len = 7;
    wreg(1, 32'h1111);
    wreg(0, 32'h3);
    wait_irq(200);
    chk("R10 timeout irq", 32'(irq), 1);
    rreg(5, v); chk("R10 timeout flag", v, 32'h10);
    rreg(9, v); chk("R10 partial residue", v, 5);
    chk("R10 irq cleared", 32'(irq), 0);
    rx_len = 12;
    wait_irq(200);
    rreg(5, v); chk("R10 slot completes after data returns", v, 32'h1);
    chk("R10 all writes seen", 32'(wr_q.size()), 0);

    // R11 bus error with stop on error
    err_on = 1'b1; err_addr = 8'h61;
    wreg(8, 32'h60); wreg(9, 3);
    push_tx(32'h60, 1);
    wreg(1, 32'h30101);
    wreg(0, 32'h1);
    wait_irq(200);
    rreg(5, v); chk("R11 error flag", v, 32'h100);
    rreg(0, v); chk("R11 stopped on error", v, 0);
    rreg(9, v); chk("R11 failed byte consumed", v, 1);
    repeat (20) @(negedge clk);
    chk("R11 no tx after error", 32'(tx_q.size()), 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule